// File: doc/BRIEF.md
# Serial Register-Bank Slave

This block is a two-wire (I2C-style) slave that lets a bus host reach a small bank of 8-bit control registers. It oversamples SCL and SDA with the system clock and finds Start and Stop conditions. It compares the 7-bit device address with a parameter. The first byte after the address loads an internal pointer, which selects the register for the next transfer. Later bytes are either written to consecutive registers or streamed back from them. The pointer moves up by one after every byte. The pointer itself can only be written. The block pulls SDA low through an open-drain enable, both for acknowledges and for zero bits of read data.

A read is set up with a write-direction address and a pointer byte, then a repeated Start and the address with the direction bit set. A Start abandons whatever is in progress and begins address reception again. A Stop returns the block to idle. A pointer byte naming a register that does not exist is refused. A write byte that would land past the last register is also refused. Both refusals leave the bus untouched until the next Start. A read that runs past the last register keeps returning the last register until the host declines to acknowledge. Every accepted write also appears on a one-cycle parallel strobe with address and data.

The controller is one state machine with these states:
- `ST_IDLE`: waits for a Start. It is also where the block parks after a refusal.
- `ST_DEVADDR`: shifts in the address byte.
- `ST_DEV_ACK`: acknowledges a matching address.
- `ST_SUB` and `ST_SUB_ACK`: take in and acknowledge the pointer byte.
- `ST_WDATA` and `ST_WR_ACK`: take in, store and acknowledge a write byte.
- `ST_RDATA`: drives a byte, MSB first.
- `ST_RD_ACK`: samples the host's acknowledge.

The transitions are:
- `ST_DEVADDR` goes to `ST_DEV_ACK` on a match, or to `ST_IDLE` on a mismatch.
- `ST_DEV_ACK` goes to `ST_SUB` (write) or `ST_RDATA` (read).
- `ST_SUB` goes to `ST_SUB_ACK` if the pointer byte is valid, otherwise to `ST_IDLE`.
- `ST_SUB_ACK` and `ST_WR_ACK` go to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WR_ACK` while the pointer is in range, otherwise to `ST_IDLE`.
- `ST_RDATA` goes to `ST_RD_ACK`.
- `ST_RD_ACK` goes back to `ST_RDATA` on a host ACK, or to `ST_IDLE` on a host NACK.
- Any state goes to `ST_DEVADDR` on a Start, or to `ST_IDLE` on a Stop.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset, SDA is released (`sda_oe`=0), `wr_en` is low and every register reads back as 0x00.
- R2: The first byte after a Start holds the 7-bit device address, MSB first, followed by a direction bit (0 = write, 1 = read). A matching address is acknowledged by holding SDA low through the ninth SCL pulse. A mismatching one is not acknowledged, and later bytes get no ACK and cause no write until the next Start.
- R3: In a write, the byte after the address sets the pointer and is ACKed if it is below `NUM_REGS`. Each later byte is ACKed, stored at the pointer, and shown on `wr_en` with `wr_addr` and `wr_data`; the pointer then increments.
- R4: A pointer byte of `NUM_REGS` or more is not acknowledged, and no further byte is acknowledged or written until the next Start.
- R5: A write byte arriving when the pointer has passed register `NUM_REGS-1` is not stored, is not acknowledged, and the block goes idle.
- R6: After a pointer write, a repeated Start and a read-direction address, bytes are driven MSB first starting at the pointed register. The pointer advances after each byte. The pointer value survives the repeated Start.
- R7: A read that runs past register `NUM_REGS-1` keeps returning that register's contents until the host leaves SDA high on the ninth pulse. SDA is then released.
- R8: A Start in the middle of a transfer restarts address reception. A Stop returns the block to idle, so a following byte without a Start is not acknowledged.
- R9: `sda_oe` changes only after a detected SCL falling edge (or a Start or Stop), so it never changes while SCL is high.
- R10: `wr_en` is a single-cycle pulse per stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain), 0 releases it |
| wr_en | output | 1 | One-cycle strobe for each stored byte |
| wr_addr | output | $clog2(NUM_REGS) | Register index of the stored byte |
| wr_data | output | 8 | Value of the stored byte |

## Verification
A wrong state in this controller shows up on the bus within one byte: the ninth-pulse acknowledge is missing or extra, or read data comes from the wrong register. Both are seen at the SCL-high sample point of the same byte. A wrong pointer shows either as a `wr_addr` value that does not match the expected register, in the cycle after the eighth falling edge, or as wrong read-back data in the next read. A mis-handled Start or Stop shows as a byte that is acknowledged when it should not be, or the reverse.

// File: rtl/regsl_pkg.sv
package regsl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEV_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_WDATA,
        ST_WR_ACK,
        ST_RDATA,
        ST_RD_ACK
    } eng_state_t;

endpackage

// File: rtl/regsl_bus_sampler.sv
module regsl_bus_sampler #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int PIPE_W = SYNC_N + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;
    logic              scl_s;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[SYNC_N-1];
    assign scl_q = scl_pipe[SYNC_N];
    assign sda_s = sda_pipe[SYNC_N-1];
    assign sda_q = sda_pipe[SYNC_N];

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/regsl_regfile.sv
module regsl_regfile #(
    parameter int NUM_REGS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr,
    input  logic [7:0]                  wr_data,
    input  logic [$clog2(NUM_REGS)-1:0] rd_idx,
    output logic [7:0]                  rd_data
);

    logic [NUM_REGS-1:0][7:0] regs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (wr_en) begin
            regs[wr_addr] <= wr_data;
        end
    end

    assign rd_data = regs[rd_idx];

    // R3: contents change only through the write strobe
    p_hold_without_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs));

endmodule

// File: rtl/regsl_engine.sv
module regsl_engine
    import regsl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NUM_REGS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sda_s,
    input  logic                        scl_rise,
    input  logic                        scl_fall,
    input  logic                        start_det,
    input  logic                        stop_det,
    input  logic [7:0]                  rd_data,
    output logic [$clog2(NUM_REGS)-1:0] rd_idx,
    output logic                        wr_en,
    output logic [$clog2(NUM_REGS)-1:0] wr_addr,
    output logic [7:0]                  wr_data,
    output logic                        sda_oe
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int PTR_W = $clog2(NUM_REGS + 1);

    eng_state_t        state;
    eng_state_t        state_d;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [PTR_W-1:0]  ptr;
    logic              rw_bit;
    logic              host_ack;

    logic byte_done;
    logic addr_hit;
    logic sub_ok;
    logic ptr_ok;
    logic rx_state;

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == DEV_ADDR);
    assign sub_ok    = (int'(shreg) < NUM_REGS);
    assign ptr_ok    = (ptr < PTR_W'(NUM_REGS));
    assign rx_state  = (state == ST_DEVADDR) || (state == ST_SUB) || (state == ST_WDATA);
    assign rd_idx    = ptr_ok ? ptr[IDX_W-1:0] : IDX_W'(NUM_REGS - 1);

    // next-state decision
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:    state_d = ST_IDLE;
            ST_DEVADDR: if (byte_done) state_d = addr_hit ? ST_DEV_ACK : ST_IDLE;
            ST_DEV_ACK: if (scl_fall)  state_d = rw_bit ? ST_RDATA : ST_SUB;
            ST_SUB:     if (byte_done) state_d = sub_ok ? ST_SUB_ACK : ST_IDLE;
            ST_SUB_ACK: if (scl_fall)  state_d = ST_WDATA;
            ST_WDATA:   if (byte_done) state_d = ptr_ok ? ST_WR_ACK : ST_IDLE;
            ST_WR_ACK:  if (scl_fall)  state_d = ST_WDATA;
            ST_RDATA:   if (byte_done) state_d = ST_RD_ACK;
            ST_RD_ACK:  if (scl_fall)  state_d = host_ack ? ST_RDATA : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (start_det) begin
            state_d = ST_DEVADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // datapath: bit counter, shifter, pointer, write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            rw_bit   <= 1'b0;
            host_ack <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det || stop_det) begin
                bit_cnt <= '0;
            end else if (scl_rise) begin
                bit_cnt <= bit_cnt + 4'd1;
                if (rx_state) begin
                    shreg <= {shreg[6:0], sda_s};
                end
                if (state == ST_RD_ACK) begin
                    host_ack <= ~sda_s;
                end
            end else if (scl_fall) begin
                unique case (state)
                    ST_DEVADDR: if (bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        rw_bit  <= shreg[0];
                    end
                    ST_SUB: if (bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        if (sub_ok) ptr <= PTR_W'(shreg);
                    end
                    ST_WDATA: if (bit_cnt == 4'd8) begin
                        bit_cnt <= '0;
                        if (ptr_ok) begin
                            wr_en   <= 1'b1;
                            wr_addr <= ptr[IDX_W-1:0];
                            wr_data <= shreg;
                            ptr     <= ptr + PTR_W'(1);
                        end
                    end
                    ST_DEV_ACK: begin
                        bit_cnt <= '0;
                        if (rw_bit) shreg <= rd_data;
                    end
                    ST_RDATA: begin
                        if (bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            if (ptr_ok) ptr <= ptr + PTR_W'(1);
                        end else begin
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                    ST_RD_ACK: begin
                        bit_cnt <= '0;
                        if (host_ack) shreg <= rd_data;
                    end
                    default: bit_cnt <= '0;
                endcase
            end
        end
    end

    // open-drain output
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_SUB_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RDATA:                          sda_oe = ~shreg[7];
            default:                           sda_oe = 1'b0;
        endcase
    end

    // R9: SDA drive moves only after an SCL fall or a bus condition
    p_oe_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

    // R3: a stored byte coincides with entering the write acknowledge
    p_wr_with_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_WR_ACK));

    // R10: write strobe lasts one cycle
    p_wr_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R8: a Stop always leaves the block idle with SDA released
    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE) && !sda_oe);

    // R6: no register store while data is streaming out
    p_no_wr_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA) |-> !wr_en);

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h2A,
    parameter int         NUM_REGS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_oe,
    output logic                        wr_en,
    output logic [$clog2(NUM_REGS)-1:0] wr_addr,
    output logic [7:0]                  wr_data
);

    localparam int IDX_W = $clog2(NUM_REGS);

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic [IDX_W-1:0] rd_idx;
    logic [7:0]       rd_data;

    regsl_bus_sampler #(.SYNC_N(2)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    regsl_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_idx    (rd_idx),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    regsl_regfile #(.NUM_REGS(NUM_REGS)) u_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: tb/sim_i2c_regbank_slave.sv
module sim_i2c_regbank_slave;

    localparam int         CLK_PERIOD = 10;
    localparam int         H          = 8;
    localparam int         NREG       = 8;
    localparam logic [6:0] DADDR      = 7'h2A;
    localparam logic [7:0] DEV_W      = {DADDR, 1'b0};
    localparam logic [7:0] DEV_R      = {DADDR, 1'b1};
    localparam int         NVEC       = 6;
    // {subaddress, data}
    localparam logic [15:0] VEC [NVEC] = '{16'h005A, 16'h03C3, 16'h0781,
                                           16'h01FF, 16'h0566, 16'h023C};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;

    int         checks = 0;
    int         fails = 0;
    int         wr_cnt = 0;
    logic [2:0] last_addr = '0;
    logic [7:0] last_data = '0;
    logic       wr_prev = 1'b0;
    int         wr_wide = 0;
    logic       oe_prev = 1'b0;
    int         oe_bad = 0;
    logic [7:0] model [NREG];
    logic [7:0] rb [4];
    logic       ack;
    logic       done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_slave #(.DEV_ADDR(DADDR), .NUM_REGS(NREG)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            wr_cnt    <= wr_cnt + 1;
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
        if (wr_en && wr_prev) wr_wide <= wr_wide + 1;
        wr_prev <= wr_en;
        if (rst_n && (sda_oe !== oe_prev) && scl_m) oe_bad <= oe_bad + 1;
        oe_prev <= sda_oe;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; tick(H);
        scl_m = 1'b1; tick(2*H);
        scl_m = 1'b0; tick(H);
    endtask

    // ack_o = 1 when the slave acknowledged (SDA low on ninth pulse)
    task automatic send_byte(input logic [7:0] b, output logic ack_o);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        ack_o = ~sda_line; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(H);
            scl_m = 1'b1; tick(H);
            b = {b[6:0], sda_line}; tick(H);
            scl_m = 1'b0;
        end
        bit_out(~mack);
    endtask

    task automatic read_burst(input logic [7:0] sub, input int n);
        logic a;
        bus_start();
        send_byte(DEV_W, a);
        send_byte(sub, a);
        bus_start();
        send_byte(DEV_R, a);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        tick(5);
        // R1: reset outputs
        check("R1 sda_oe in reset", int'(sda_oe), 0);
        check("R1 wr_en in reset", int'(wr_en), 0);
        rst_n = 1'b1;
        tick(5);
        check("R1 sda_oe after reset", int'(sda_oe), 0);
        read_burst(8'h04, 1);
        check("R1 register reads zero", int'(rb[0]), 0);

        // table walk: single write then single read back (R2, R3, R6, R10)
        for (int v = 0; v < NVEC; v++) begin
            logic a0, a1, a2;
            int   cnt0;
            cnt0 = wr_cnt;
            bus_start();
            send_byte(DEV_W, a0);
            send_byte(VEC[v][15:8], a1);
            send_byte(VEC[v][7:0], a2);
            bus_stop();
            model[VEC[v][10:8]] = VEC[v][7:0];
            check("R2 address ack", int'(a0), 1);
            check("R3 subaddress ack", int'(a1), 1);
            check("R3 data ack", int'(a2), 1);
            check("R10 one strobe per byte", wr_cnt - cnt0, 1);
            check("R3 strobe address", int'(last_addr), int'(VEC[v][10:8]));
            check("R3 strobe data", int'(last_data), int'(VEC[v][7:0]));
            read_burst(VEC[v][15:8], 1);
            check("R6 read back", int'(rb[0]), int'(VEC[v][7:0]));
        end

        // R3/R6: burst write then burst read with auto-increment
        begin
            logic a;
            int   cnt0;
            cnt0 = wr_cnt;
            bus_start();
            send_byte(DEV_W, a);
            send_byte(8'h02, a);
            send_byte(8'hA1, a);
            send_byte(8'hB2, a);
            send_byte(8'hC3, a);
            bus_stop();
            model[2] = 8'hA1; model[3] = 8'hB2; model[4] = 8'hC3;
            check("R3 burst strobes", wr_cnt - cnt0, 3);
            check("R3 burst last address", int'(last_addr), 4);
            read_burst(8'h02, 3);
            check("R6 burst byte0", int'(rb[0]), 8'hA1);
            check("R6 burst byte1", int'(rb[1]), 8'hB2);
            check("R6 burst byte2", int'(rb[2]), 8'hC3);
        end

        // R2: wrong device address
        begin
            logic a0, a1, a2;
            int   cnt0;
            cnt0 = wr_cnt;
            bus_start();
            send_byte(8'h66, a0);
            send_byte(8'h01, a1);
            send_byte(8'h77, a2);
            bus_stop();
            check("R2 mismatch no ack", int'(a0), 0);
            check("R2 mismatch later bytes no ack", int'(a1 | a2), 0);
            check("R2 mismatch no write", wr_cnt - cnt0, 0);
        end

        // R4: invalid subaddress
        begin
            logic a0, a1, a2;
            int   cnt0;
            cnt0 = wr_cnt;
            bus_start();
            send_byte(DEV_W, a0);
            send_byte(8'(NREG), a1);
            send_byte(8'h5E, a2);
            bus_stop();
            check("R4 address still acked", int'(a0), 1);
            check("R4 invalid subaddress nack", int'(a1), 0);
            check("R4 following byte nack", int'(a2), 0);
            check("R4 no write", wr_cnt - cnt0, 0);
        end

        // R5: write past top register
        begin
            logic a0, a1;
            int   cnt0;
            cnt0 = wr_cnt;
            bus_start();
            send_byte(DEV_W, a0);
            send_byte(8'(NREG - 1), a0);
            send_byte(8'h11, a0);
            send_byte(8'h22, a1);
            bus_stop();
            model[NREG-1] = 8'h11;
            check("R5 top byte acked", int'(a0), 1);
            check("R5 overflow byte nack", int'(a1), 0);
            check("R5 only one store", wr_cnt - cnt0, 1);
            read_burst(8'(NREG - 1), 1);
            check("R5 top keeps first value", int'(rb[0]), 8'h11);
        end

        // R7: read past top register repeats it
        read_burst(8'(NREG - 2), 4);
        check("R7 byte below top", int'(rb[0]), int'(model[NREG-2]));
        check("R7 top", int'(rb[1]), int'(model[NREG-1]));
        check("R7 repeat top", int'(rb[2]), int'(model[NREG-1]));
        check("R7 repeat top again", int'(rb[3]), int'(model[NREG-1]));
        check("R7 SDA released after nack", int'(sda_oe), 0);

        // R8: Start mid transfer restarts address reception
        begin
            logic a0, a1;
            bus_start();
            send_byte(DEV_W, a0);
            send_byte(8'h05, a0);
            bus_start();
            send_byte(DEV_W, a0);
            send_byte(8'h01, a0);
            send_byte(8'h99, a1);
            bus_stop();
            model[1] = 8'h99;
            check("R8 restart accepted", int'(a0 & a1), 1);
            read_burst(8'h05, 1);
            check("R8 abandoned target untouched", int'(rb[0]), int'(model[5]));
            read_burst(8'h01, 1);
            check("R8 restarted write landed", int'(rb[0]), 8'h99);
        end

        // R8: Stop returns to idle
        begin
            logic a;
            int   cnt0;
            cnt0 = wr_cnt;
            bus_start();
            send_byte(DEV_W, a);
            send_byte(8'h00, a);
            bus_stop();
            scl_m = 1'b0; tick(H);
            send_byte(8'h44, a);
            bus_stop();
            check("R8 byte after stop nack", int'(a), 0);
            check("R8 no write after stop", wr_cnt - cnt0, 0);
        end

        check("R9 sda_oe never moves with SCL high", oe_bad, 0);
        check("R10 strobe never wider than one cycle", wr_wide, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule